// File: doc/BRIEF.md
# Four-Channel Activity and Reset Controller

This block keeps the active or standby state of four channels and the default configuration that every reset loads. A command decoder outside the block issues single-cycle activate and deactivate pulses. Each pulse acts only on the channels currently selected in a channel-enable register, which the decoder can also write. A channel never becomes active by any path other than an activate command.

Reset comes from four sources. The asynchronous active-low pin covers power-up and the hardware pin. A software reset pulse is the third. The fourth is a detector that counts rising edges of the serial data clock while chip select is held low and fires a single reset pulse at the sixteenth edge. When every channel is in standby and low-power operation is requested, the block drops its internal clock enable to one cycle in six, raises a clock-fail status flag, and gates all of its own state updates with that enable.

Top module: `chan_activity_ctrl`

## Requirements
- R1: After the reset pin is released, all channels are inactive and the enable register holds 4'hF. Transmit and receive slots for channel i equal i, with channel i at bits [i*7 +: 7] of the slot buses. The clock-slot offset is 0, transmit-on-negative-edge is 1, A-law select is 1, debounce is 8, clock fail is 0 and clock enable is 1.
- R2: An activate pulse sets, at the next clock edge, the active bit of every channel selected in the enable register and leaves the other channels unchanged.
- R3: A deactivate pulse clears the active bit of every selected channel and leaves unselected channels unchanged. When activate and deactivate arrive in the same cycle, deactivate wins.
- R4: An enable-register write loads the 4-bit data at the next edge. An activate issued in the same cycle uses the enable value held before the write.
- R5: A software reset pulse returns active to 0 and enable to 4'hF at the next edge.
- R6: While chip select is low, the sixteenth serial-clock rising edge produces exactly one single-cycle reset pulse on cs_rst_o, and that pulse resets the state as in R5. Edges beyond the sixteenth produce no further pulse, and fifteen edges produce none.
- R7: Chip select going high clears the edge count, so two bursts of fewer than sixteen edges separated by chip select high produce no reset.
- R8: With low power requested and all channels inactive, clk_fail_o is 1 from the second cycle on and clk_en_o is high in exactly one cycle out of every six.
- R9: In low-power mode, an activate pulse that falls in a cycle with clk_en_o low has no effect. One that falls in a cycle with clk_en_o high takes effect.
- R10: In the cycle after any channel becomes active, clk_fail_o is 0 and clk_en_o stays high.
- R11: With low power requested while a channel is active, clk_fail_o stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset (power-up and pin) |
| sw_rst_i | input | 1 | Software reset pulse |
| cs_ni | input | 1 | Serial interface chip select, active low |
| sclk_i | input | 1 | Serial data clock, sampled by clk_i |
| act_i | input | 1 | Activate command pulse |
| deact_i | input | 1 | Deactivate command pulse |
| en_wr_i | input | 1 | Channel-enable register write strobe |
| en_data_i | input | 4 | Channel-enable write data, bit i for channel i |
| lowpwr_i | input | 1 | Low-power operation requested |
| active_o | output | 4 | Active state per channel |
| chan_en_o | output | 4 | Channel-enable register |
| clk_en_o | output | 1 | Internal clock enable |
| clk_fail_o | output | 1 | Reduced-clock status flag |
| cs_rst_o | output | 1 | Reset pulse from the chip-select detector |
| tx_slots_o | output | 28 | Transmit time slot per channel, 7 bits each |
| rx_slots_o | output | 28 | Receive time slot per channel, 7 bits each |
| clk_slot_o | output | 7 | Clock-slot offset |
| tx_neg_o | output | 1 | Transmit on negative clock edge |
| alaw_o | output | 1 | A-law companding selected |
| debounce_o | output | 5 | Supervision debounce time in ms |

## Verification
The hardest case to reach is a command that lands in one of the five dead cycles of the reduced clock. The command still has to be lost, and the next live cycle still has to honour it. The stimulus first deactivates every channel with low power requested. It then watches clk_en_o at falling edges until it sees a dead cycle and injects an activate there. After that it waits for a live cycle and repeats the command, which also shows the exit from low power one cycle later. The chip-select detector is driven with bursts of exactly fifteen, sixteen and twenty edges, and with two fifteen-edge bursts split by chip select going high.

// File: rtl/chan_ctrl_pkg.sv
package chan_ctrl_pkg;
  localparam int NCH      = 4;
  localparam int SLOT_W   = 7;
  localparam int DB_W     = 5;
  localparam int DB_DEF   = 8;
  localparam int CS_EDGES = 16;
  localparam int DIV      = 6;

  typedef struct packed {
    logic              alaw;
    logic              tx_neg;
    logic [SLOT_W-1:0] clk_slot;
    logic [DB_W-1:0]   debounce;
  } glb_cfg_t;

  localparam glb_cfg_t CFG_DEF = '{alaw: 1'b1, tx_neg: 1'b1, clk_slot: '0,
                                   debounce: DB_W'(DB_DEF)};
endpackage

// File: rtl/chan_cs_reset_det.sv
module chan_cs_reset_det #(
  parameter int EDGES = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ce_i,
  input  logic cs_ni,
  input  logic sclk_i,
  output logic rst_pulse_o
);
  localparam int CW = $clog2(EDGES + 1);

  logic          sclk_q, pulse_q;
  logic [CW-1:0] cnt_q;
  logic          rise;

  assign rise = sclk_i & ~sclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q  <= 1'b0;
      cnt_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= 1'b0;
      if (ce_i) begin
        sclk_q <= sclk_i;
        if (cs_ni) cnt_q <= '0;
        else if (rise && cnt_q < CW'(EDGES)) begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == CW'(EDGES - 1)) pulse_q <= 1'b1;
        end
      end
    end
  end

  assign rst_pulse_o = pulse_q;

  // R6
  single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_q |=> !pulse_q);
  // R6
  cnt_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(EDGES));
  // R7
  cs_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_i && cs_ni) |=> cnt_q == '0);
endmodule

// File: rtl/chan_clk_div.sv
module chan_clk_div #(
  parameter int DIV = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lowpwr_i,
  input  logic any_active_i,
  output logic ce_o,
  output logic lp_o
);
  localparam int CW = $clog2(DIV);

  logic          lp_q;
  logic [CW-1:0] div_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lp_q  <= 1'b0;
      div_q <= '0;
    end else begin
      lp_q <= lowpwr_i & ~any_active_i;
      if (!lp_q || div_q == CW'(DIV - 1)) div_q <= '0;
      else                                div_q <= div_q + 1'b1;
    end
  end

  assign ce_o = ~lp_q | (div_q == '0);
  assign lp_o = lp_q;

  // R8
  lp_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lp_q && $past(lp_q) && $past(ce_o)) |-> !ce_o);
  // R10
  lp_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_active_i |=> (!lp_q && ce_o));
endmodule

// File: rtl/chan_state_regs.sv
module chan_state_regs
  import chan_ctrl_pkg::*;
#(
  parameter int NCH  = 4,
  parameter int SW   = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_i,
  input  logic              soft_rst_i,
  input  logic              act_i,
  input  logic              deact_i,
  input  logic              en_wr_i,
  input  logic [NCH-1:0]    en_data_i,
  output logic [NCH-1:0]    active_o,
  output logic [NCH-1:0]    en_o,
  output logic [NCH*SW-1:0] tx_slots_o,
  output logic [NCH*SW-1:0] rx_slots_o,
  output glb_cfg_t          cfg_o
);
  logic [NCH-1:0] active_q, en_q;
  glb_cfg_t       cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= '0;
      en_q     <= '1;
      cfg_q    <= CFG_DEF;
    end else if (soft_rst_i) begin
      active_q <= '0;
      en_q     <= '1;
      cfg_q    <= CFG_DEF;
    end else if (ce_i) begin
      if (en_wr_i) en_q <= en_data_i;
      if (deact_i)     active_q <= active_q & ~en_q;
      else if (act_i)  active_q <= active_q | en_q;
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_slot
    logic [SW-1:0] tx_q, rx_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni || soft_rst_i) begin
        tx_q <= SW'(i);
        rx_q <= SW'(i);
      end
    end
    assign tx_slots_o[i*SW +: SW] = tx_q;
    assign rx_slots_o[i*SW +: SW] = rx_q;
  end

  assign active_o = active_q;
  assign en_o     = en_q;
  assign cfg_o    = cfg_q;

  // R2
  act_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((active_q & ~$past(active_q)) != '0) |-> $past(act_i && ce_i && !deact_i));
  // R3
  deact_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (deact_i && ce_i && !soft_rst_i) |=> (active_q & $past(en_q)) == '0);
  // R5
  soft_rst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |=> (active_q == '0 && en_q == '1));
endmodule

// File: rtl/chan_activity_ctrl.sv
module chan_activity_ctrl
  import chan_ctrl_pkg::*;
#(
  parameter int NCH_P    = chan_ctrl_pkg::NCH,
  parameter int SLOT_P   = chan_ctrl_pkg::SLOT_W,
  parameter int EDGES_P  = chan_ctrl_pkg::CS_EDGES,
  parameter int DIV_P    = chan_ctrl_pkg::DIV
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  sw_rst_i,
  input  logic                  cs_ni,
  input  logic                  sclk_i,
  input  logic                  act_i,
  input  logic                  deact_i,
  input  logic                  en_wr_i,
  input  logic [NCH_P-1:0]      en_data_i,
  input  logic                  lowpwr_i,
  output logic [NCH_P-1:0]      active_o,
  output logic [NCH_P-1:0]      chan_en_o,
  output logic                  clk_en_o,
  output logic                  clk_fail_o,
  output logic                  cs_rst_o,
  output logic [NCH_P*SLOT_P-1:0] tx_slots_o,
  output logic [NCH_P*SLOT_P-1:0] rx_slots_o,
  output logic [SLOT_W-1:0]     clk_slot_o,
  output logic                  tx_neg_o,
  output logic                  alaw_o,
  output logic [DB_W-1:0]       debounce_o
);
  logic     ce, lp, cs_rst, soft_rst;
  glb_cfg_t cfg;

  assign soft_rst = sw_rst_i | cs_rst;

  chan_cs_reset_det #(.EDGES(EDGES_P)) u_det (
    .clk_i(clk_i), .rst_ni(rst_ni), .ce_i(ce), .cs_ni(cs_ni),
    .sclk_i(sclk_i), .rst_pulse_o(cs_rst)
  );

  chan_clk_div #(.DIV(DIV_P)) u_div (
    .clk_i(clk_i), .rst_ni(rst_ni), .lowpwr_i(lowpwr_i),
    .any_active_i(|active_o), .ce_o(ce), .lp_o(lp)
  );

  chan_state_regs #(.NCH(NCH_P), .SW(SLOT_P)) u_st (
    .clk_i(clk_i), .rst_ni(rst_ni), .ce_i(ce), .soft_rst_i(soft_rst),
    .act_i(act_i), .deact_i(deact_i), .en_wr_i(en_wr_i), .en_data_i(en_data_i),
    .active_o(active_o), .en_o(chan_en_o), .tx_slots_o(tx_slots_o),
    .rx_slots_o(rx_slots_o), .cfg_o(cfg)
  );

  assign clk_en_o   = ce;
  assign clk_fail_o = lp;
  assign cs_rst_o   = cs_rst;
  assign clk_slot_o = cfg.clk_slot;
  assign tx_neg_o   = cfg.tx_neg;
  assign alaw_o     = cfg.alaw;
  assign debounce_o = cfg.debounce;

  // R11
  busy_no_fail_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_o != '0) |=> !clk_fail_o);
  // R6
  cs_rst_effect_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_rst_o |=> (active_o == '0 && chan_en_o == '1));
endmodule

// File: tb/chan_activity_ctrl_test.sv
module chan_activity_ctrl_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sw_rst = 0, cs_n = 1, sclk = 0, act = 0, deact = 0, en_wr = 0, lowpwr = 0;
  logic [3:0] en_data = '0;
  logic [3:0] active, chan_en;
  logic clk_en, clk_fail, cs_rst, tx_neg, alaw;
  logic [27:0] tx_slots, rx_slots;
  logic [6:0] clk_slot;
  logic [4:0] debounce;
  int errors = 0, checks = 0, pulses = 0;

  always #10 clk = ~clk;

  chan_activity_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .sw_rst_i(sw_rst), .cs_ni(cs_n), .sclk_i(sclk),
    .act_i(act), .deact_i(deact), .en_wr_i(en_wr), .en_data_i(en_data),
    .lowpwr_i(lowpwr), .active_o(active), .chan_en_o(chan_en), .clk_en_o(clk_en),
    .clk_fail_o(clk_fail), .cs_rst_o(cs_rst), .tx_slots_o(tx_slots),
    .rx_slots_o(rx_slots), .clk_slot_o(clk_slot), .tx_neg_o(tx_neg),
    .alaw_o(alaw), .debounce_o(debounce)
  );

  always @(negedge clk) if (rst_n && cs_rst) pulses++;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic cmd(input logic a, input logic d, input logic w, input logic [3:0] data);
    @(negedge clk);
    act = a; deact = d; en_wr = w; en_data = data;
    @(negedge clk);
    act = 0; deact = 0; en_wr = 0;
  endtask

  task automatic sclk_rises(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); sclk = 1;
      repeat (2) @(negedge clk); sclk = 0;
      @(negedge clk);
    end
  endtask

  // {act, deact, en_wr, en_data, exp_active, exp_en}
  localparam logic [14:0] VEC [10] = '{
    {3'b100, 4'h0, 4'hF, 4'hF},   // R2
    {3'b001, 4'h5, 4'hF, 4'h5},   // R4
    {3'b010, 4'h0, 4'hA, 4'h5},   // R3
    {3'b100, 4'h0, 4'hF, 4'h5},   // R2
    {3'b001, 4'h2, 4'hF, 4'h2},   // R4
    {3'b010, 4'h0, 4'hD, 4'h2},   // R3
    {3'b001, 4'h4, 4'hD, 4'h4},   // R4
    {3'b110, 4'h0, 4'h9, 4'h4},   // R3 deact wins
    {3'b101, 4'h3, 4'hD, 4'h3},   // R4 old enable used
    {3'b100, 4'h0, 4'hF, 4'h3}    // R2
  };

  initial begin
    #(20 * 100000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    chk("R1 active", active, 0);
    chk("R1 enable", chan_en, 4'hF);
    chk("R1 tx slots", tx_slots, {7'd3, 7'd2, 7'd1, 7'd0});
    chk("R1 rx slots", rx_slots, {7'd3, 7'd2, 7'd1, 7'd0});
    chk("R1 cfg", {clk_slot, tx_neg, alaw, debounce}, {7'd0, 1'b1, 1'b1, 5'd8});
    chk("R1 clocks", {clk_fail, clk_en}, 2'b01);

    for (int i = 0; i < 10; i++) begin
      cmd(VEC[i][14], VEC[i][13], VEC[i][12], VEC[i][11:8]);
      chk($sformatf("R2/R3/R4 vec%0d active", i), active, VEC[i][7:4]);
      chk($sformatf("R2/R3/R4 vec%0d enable", i), chan_en, VEC[i][3:0]);
    end

    // R5
    @(negedge clk); sw_rst = 1;
    @(negedge clk); sw_rst = 0;
    chk("R5 active", active, 0);
    chk("R5 enable", chan_en, 4'hF);

    // R6: 15 edges none, 16th fires once, extra edges none
    cmd(1, 0, 0, 0);
    @(negedge clk); cs_n = 0;
    sclk_rises(15);
    chk("R6 no pulse at 15", pulses, 0);
    chk("R6 active kept", active, 4'hF);
    sclk_rises(1);
    chk("R6 pulse at 16", pulses, 1);
    chk("R6 reset active", active, 0);
    cmd(1, 0, 0, 0);
    sclk_rises(4);
    chk("R6 saturate", pulses, 1);
    chk("R6 active after extra", active, 4'hF);
    @(negedge clk); cs_n = 1;
    @(negedge clk);

    // R7
    cs_n = 0;
    sclk_rises(15);
    cs_n = 1; repeat (2) @(negedge clk);
    cs_n = 0;
    sclk_rises(15);
    cs_n = 1; @(negedge clk);
    chk("R7 no pulse", pulses, 1);
    chk("R7 active kept", active, 4'hF);

    // R11
    lowpwr = 1;
    repeat (3) @(negedge clk);
    chk("R11 no fail while busy", clk_fail, 0);

    // R8
    cmd(0, 1, 0, 0);
    @(negedge clk);
    chk("R8 fail set", clk_fail, 1);
    begin
      int n = 0;
      for (int i = 0; i < 12; i++) begin
        if (clk_en) n++;
        @(negedge clk);
      end
      chk("R8 enable 2 of 12", n, 2);
    end

    // R9 dead cycle
    while (clk_en) @(negedge clk);
    act = 1; @(negedge clk); act = 0;
    chk("R9 dead cycle ignored", active, 0);
    chk("R9 still low power", clk_fail, 1);
    while (!clk_en) @(negedge clk);
    act = 1; @(negedge clk); act = 0;
    chk("R9 live cycle taken", active, 4'hF);
    @(negedge clk);
    // R10
    chk("R10 fail cleared", clk_fail, 0);
    chk("R10 enable high", clk_en, 1);
    @(negedge clk);
    chk("R10 enable held", clk_en, 1);

    lowpwr = 0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule